// File: doc/BRIEF.md
# Serial-Addressed Eight-Pin Port Expander Core

This core gives an external controller eight general-purpose pins through a four-wire serial slave link (clock idle low, data captured on the rising clock edge, most significant bit first). A frame opens when chip select goes low. The first byte is a control byte. It carries a fixed tag, a 3-bit device number and a read/write flag. The second byte selects a register, and one or more data bytes follow. Up to eight cores can share one chip select, each with its own 3-bit strap value. Each register is one byte wide. The registers hold the pin direction, input inversion, interrupt enable, compare value, interrupt mode, configuration, pull-up enable and output latch. Three more are status registers that only the hardware writes: the pending flags, the captured port value, and the live port value.

The link sequencer has five named states. CTRL receives the control byte. ADDR receives the register number. WRITE stores data bytes. READ returns data bytes. DROP swallows the rest of a frame meant for another device. The transitions are:
- CTRL→ADDR when the control byte is accepted, and CTRL→DROP when it is not.
- ADDR→READ or ADDR→WRITE, according to the read/write flag.
- WRITE and READ stay put byte after byte.
- Any state returns to CTRL while chip select is high.

Top module: `gpx_expander`

## Requirements
- R1: After reset the direction register (0x00) reads 0xFF, so every pin is an input and pin_oe_o is 0x00. All other storage registers read 0x00, and pin_out_o and pin_pu_o are 0x00.
- R2: A frame is a control byte 0100_DDD_W, then a register byte, then data bytes. W=0 writes and W=1 reads. The storage registers at 0x00–0x06 and 0x0A read back the value last written.
- R3: pin_oe_o is the inverse of the direction register, so a 0 bit drives the pin. pin_out_o equals the output latch (0x0A), and pin_pu_o equals the pull-up register (0x06).
- R4: A read of the port register (0x09) returns pin_i XOR the inversion register (0x01).
- R5: Writes to the status registers 0x07, 0x08 and 0x09, and to any address above 0x0A, change nothing. Reads above 0x0A return 0x00.
- R6: While configuration bit 3 is 0, the DDD field is ignored. A control byte whose upper nibble is not 0100 is ignored whatever the configuration.
- R7: While configuration bit 3 is 1, only a control byte whose DDD matches hw_addr_i is served. For any other value MISO stays 0 and no register changes.
- R8: While configuration bit 5 is 0, the register number advances after every data byte and wraps from 0x0A to 0x00.
- R9: While configuration bit 5 is 1, every data byte of a frame goes to, or comes from, the same register.
- R10: Raising chip select ends the frame at once. A partly shifted byte has no effect, and the next frame starts with a fresh control byte.
- R11: In change mode (interrupt-mode bit 0), an enabled input whose level changes sets its bit in the flag register (0x07). When no flag was pending, the port value is captured into 0x08. Reading 0x07 leaves the flags alone. Fully shifting out 0x08 or 0x09 clears them.
- R12: In compare mode (interrupt-mode bit 1), an enabled input that differs from its compare bit (0x03) sets its flag. The flag sets again after a clear for as long as the difference lasts.
- R13: Pins that are outputs, or whose enable bit is 0, never set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; serial inputs are oversampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_addr_i | input | 3 | Strap value compared with the control byte's device field |
| spi_sclk_i | input | 1 | Serial clock, idle low |
| spi_cs_n_i | input | 1 | Active-low chip select; high aborts a frame |
| spi_mosi_i | input | 1 | Serial data from the controller |
| spi_miso_o | output | 1 | Serial data to the controller, 0 when not reading |
| pin_i | input | 8 | Sampled pin levels |
| pin_oe_o | output | 8 | Per-pin drive enable |
| pin_out_o | output | 8 | Per-pin driven value |
| pin_pu_o | output | 8 | Per-pin pull-up enable |

## Verification
Addressing and pointer movement are tested with exhaustive sweeps:
- All eight device numbers with device matching on, where a design that ignored the match would let every sweep step overwrite the latch.
- A burst that crosses 0x0A, where a missing wrap would send bytes to 0x0B and leave the direction and inversion registers untouched.
- A held pointer, where a pointer that kept advancing would return three different bytes.

The volatile status registers get the closest attention. A core that cleared the flags while reading ahead would report zero on a second flag read. A core that cleared on a flag read would lose pending events. A core that gated outputs badly would flag driven pins.

An aborted frame followed by a clean write catches a bit counter that survives chip select.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int BYTE_W = 8;
    localparam int HWA_W  = 3;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [3:0] CTRL_TAG = 4'b0100;

    localparam logic [BYTE_W-1:0] A_DIR   = 8'h00;
    localparam logic [BYTE_W-1:0] A_INV   = 8'h01;
    localparam logic [BYTE_W-1:0] A_IEN   = 8'h02;
    localparam logic [BYTE_W-1:0] A_CMPV  = 8'h03;
    localparam logic [BYTE_W-1:0] A_MODE  = 8'h04;
    localparam logic [BYTE_W-1:0] A_CFG   = 8'h05;
    localparam logic [BYTE_W-1:0] A_PULL  = 8'h06;
    localparam logic [BYTE_W-1:0] A_FLAG  = 8'h07;
    localparam logic [BYTE_W-1:0] A_SNAP  = 8'h08;
    localparam logic [BYTE_W-1:0] A_PORT  = 8'h09;
    localparam logic [BYTE_W-1:0] A_LATCH = 8'h0A;
    localparam logic [BYTE_W-1:0] A_LAST  = A_LATCH;

    localparam int CFG_DEVMATCH_BIT = 3;
    localparam int CFG_HOLD_BIT     = 5;

    typedef enum logic [2:0] {
        ST_CTRL,
        ST_ADDR,
        ST_WRITE,
        ST_READ,
        ST_DROP
    } link_state_e;
endpackage

// File: rtl/gpx_spi_link.sv
module gpx_spi_link
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic              tx_load_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              miso_o,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    logic              sclk_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rise, fall;

    assign rise        = !cs_n_i && sclk_i && !sclk_q;
    assign fall        = !cs_n_i && !sclk_i && sclk_q;
    assign byte_done_o = rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign rx_byte_o   = {rx_sh[BYTE_W-2:0], mosi_i};
    assign miso_o      = tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            sclk_q <= sclk_i;
            if (cs_n_i) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
                tx_sh   <= '0;
            end else begin
                if (rise) begin
                    rx_sh   <= rx_byte_o;
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (tx_load_i)
                    tx_sh <= tx_byte_i;
                else if (fall && bit_cnt != '0)
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [BYTE_W-1:0] rd_addr_i,
    input  logic              rd_clear_i,
    input  logic [BYTE_W-1:0] pin_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [BYTE_W-1:0] dir_o,
    output logic [BYTE_W-1:0] latch_o,
    output logic [BYTE_W-1:0] pull_o,
    output logic              devmatch_o,
    output logic              hold_ptr_o
);
    logic [BYTE_W-1:0] dir_r, inv_r, ien_r, cmpv_r, mode_r, cfg_r, pull_r, latch_r;
    logic [BYTE_W-1:0] flag_r, snap_r;
    logic [BYTE_W-1:0] pin_q, pin_qq;
    logic [BYTE_W-1:0] port_v, hit, flag_base;

    assign port_v     = pin_q ^ inv_r;
    assign hit        = ien_r & dir_r & ((mode_r & (pin_q ^ cmpv_r)) | (~mode_r & (pin_q ^ pin_qq)));
    assign flag_base  = rd_clear_i ? '0 : flag_r;
    assign dir_o      = dir_r;
    assign latch_o    = latch_r;
    assign pull_o     = pull_r;
    assign devmatch_o = cfg_r[CFG_DEVMATCH_BIT];
    assign hold_ptr_o = cfg_r[CFG_HOLD_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_r   <= '1;
            inv_r   <= '0;
            ien_r   <= '0;
            cmpv_r  <= '0;
            mode_r  <= '0;
            cfg_r   <= '0;
            pull_r  <= '0;
            latch_r <= '0;
            flag_r  <= '0;
            snap_r  <= '0;
            pin_q   <= '0;
            pin_qq  <= '0;
        end else begin
            pin_q  <= pin_i;
            pin_qq <= pin_q;
            flag_r <= flag_base | hit;
            if (flag_base == '0 && hit != '0)
                snap_r <= port_v;
            if (wr_en_i) begin
                case (wr_addr_i)
                    A_DIR:   dir_r   <= wr_data_i;
                    A_INV:   inv_r   <= wr_data_i;
                    A_IEN:   ien_r   <= wr_data_i;
                    A_CMPV:  cmpv_r  <= wr_data_i;
                    A_MODE:  mode_r  <= wr_data_i;
                    A_CFG:   cfg_r   <= wr_data_i;
                    A_PULL:  pull_r  <= wr_data_i;
                    A_LATCH: latch_r <= wr_data_i;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr_i)
            A_DIR:   rd_data_o = dir_r;
            A_INV:   rd_data_o = inv_r;
            A_IEN:   rd_data_o = ien_r;
            A_CMPV:  rd_data_o = cmpv_r;
            A_MODE:  rd_data_o = mode_r;
            A_CFG:   rd_data_o = cfg_r;
            A_PULL:  rd_data_o = pull_r;
            A_FLAG:  rd_data_o = flag_r;
            A_SNAP:  rd_data_o = snap_r;
            A_PORT:  rd_data_o = port_v;
            A_LATCH: rd_data_o = latch_r;
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HWA_W-1:0]  hw_addr_i,
    input  logic              spi_sclk_i,
    input  logic              spi_cs_n_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    input  logic [BYTE_W-1:0] pin_i,
    output logic [BYTE_W-1:0] pin_oe_o,
    output logic [BYTE_W-1:0] pin_out_o,
    output logic [BYTE_W-1:0] pin_pu_o
);
    link_state_e       st_q, st_d;
    logic [BYTE_W-1:0] ptr_q, ptr_d;
    logic              rw_q, rw_d;
    logic              byte_done, tx_load, wr_en, rd_clear;
    logic [BYTE_W-1:0] rx_byte, rd_addr, rd_data, dir_v;
    logic              devmatch, hold_ptr, ctrl_ok;

    function automatic logic [BYTE_W-1:0] step(input logic [BYTE_W-1:0] p, input logic hold);
        if (hold)
            return p;
        else if (p >= A_LAST)
            return '0;
        else
            return p + 1'b1;
    endfunction

    gpx_spi_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (spi_sclk_i),
        .cs_n_i     (spi_cs_n_i),
        .mosi_i     (spi_mosi_i),
        .tx_load_i  (tx_load),
        .tx_byte_i  (rd_data),
        .miso_o     (spi_miso_o),
        .byte_done_o(byte_done),
        .rx_byte_o  (rx_byte)
    );

    gpx_regbank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (ptr_q),
        .wr_data_i (rx_byte),
        .rd_addr_i (rd_addr),
        .rd_clear_i(rd_clear),
        .pin_i     (pin_i),
        .rd_data_o (rd_data),
        .dir_o     (dir_v),
        .latch_o   (pin_out_o),
        .pull_o    (pin_pu_o),
        .devmatch_o(devmatch),
        .hold_ptr_o(hold_ptr)
    );

    assign pin_oe_o = ~dir_v;
    assign ctrl_ok  = (rx_byte[BYTE_W-1:BYTE_W-4] == CTRL_TAG) &&
                      (!devmatch || rx_byte[HWA_W:1] == hw_addr_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_CTRL;
            ptr_q <= '0;
            rw_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
            rw_q  <= rw_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        ptr_d    = ptr_q;
        rw_d     = rw_q;
        wr_en    = 1'b0;
        tx_load  = 1'b0;
        rd_clear = 1'b0;
        rd_addr  = ptr_q;
        if (spi_cs_n_i) begin
            st_d = ST_CTRL;
        end else if (byte_done) begin
            unique case (st_q)
                ST_CTRL: begin
                    if (ctrl_ok) begin
                        st_d = ST_ADDR;
                        rw_d = rx_byte[0];
                    end else begin
                        st_d = ST_DROP;
                    end
                end
                ST_ADDR: begin
                    ptr_d   = rx_byte;
                    rd_addr = rx_byte;
                    if (rw_q) begin
                        st_d    = ST_READ;
                        tx_load = 1'b1;
                    end else begin
                        st_d = ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    wr_en = 1'b1;
                    ptr_d = step(ptr_q, hold_ptr);
                end
                ST_READ: begin
                    rd_clear = (ptr_q == A_SNAP) || (ptr_q == A_PORT);
                    ptr_d    = step(ptr_q, hold_ptr);
                    rd_addr  = ptr_d;
                    tx_load  = 1'b1;
                end
                ST_DROP: ;
                default: st_d = ST_CTRL;
            endcase
        end
    end
endmodule

// File: rtl/gpx_expander_sva.sv
module gpx_expander_sva
    import gpx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input link_state_e       state,
    input logic              byte_done,
    input logic [BYTE_W-1:0] ptr,
    input logic              hold,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_data,
    input logic              miso,
    input logic [BYTE_W-1:0] pin_out
);
    a_r10_abort_to_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == ST_CTRL));

    a_r9_hold_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == ST_WRITE && hold) |=> $stable(ptr));

    a_r8_pointer_moves_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done |=> $stable(ptr));

    a_r3_latch_drives_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == A_LATCH) |=> (pin_out == $past(wr_data)));

    a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |-> !miso);
endmodule

bind gpx_expander gpx_expander_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (spi_cs_n_i),
    .state    (st_q),
    .byte_done(byte_done),
    .ptr      (ptr_q),
    .hold     (hold_ptr),
    .wr_en    (wr_en),
    .wr_data  (rx_byte),
    .miso     (spi_miso_o),
    .pin_out  (pin_out_o)
);

// File: tb/gpx_expander_test.sv
module gpx_expander_test;
    localparam logic [2:0] STRAP = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic [7:0] pins = 8'h00;
    logic [7:0] oe, outv, pu;
    int         n_checks = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    gpx_expander uut (
        .clk(clk), .rst_n(rst_n), .hw_addr_i(STRAP),
        .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi), .spi_miso_o(miso),
        .pin_i(pins), .pin_oe_o(oe), .pin_out_o(outv), .pin_pu_o(pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            @(negedge clk); mosi = tx[i];
            repeat (3) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    function automatic logic [7:0] ctl(input logic [2:0] h, input logic rd);
        return {4'b0100, h, rd};
    endfunction

    task automatic frame(input logic [7:0] c, input logic [7:0] a, input int n,
                         input logic [23:0] wd, output logic [23:0] rd);
        logic [7:0] junk, r;
        rd = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        spi_bits(c, 8, junk);
        spi_bits(a, 8, junk);
        for (int k = 0; k < n; k++) begin
            spi_bits(wd[23-8*k -: 8], 8, r);
            rd[23-8*k -: 8] = r;
        end
        repeat (2) @(negedge clk); cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] c, input logic [7:0] a, input logic [7:0] v);
        logic [23:0] r;
        frame(c, a, 1, {v, 16'h0}, r);
    endtask

    task automatic rd1(input logic [7:0] c, input logic [7:0] a, output logic [7:0] v);
        logic [23:0] r;
        frame(c, a, 1, 24'h0, r);
        v = r[23:16];
    endtask

    function automatic logic [7:0] pat(input int a);
        logic [7:0] v;
        v = 8'(8'h3C + a * 37);
        if (a == 5) v = v & ~8'h28;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v, prev;
        logic [23:0] r;
        logic [7:0]  junk;
        do_reset();

        // R1 reset state
        chk("R1 oe", oe, 8'h00);
        chk("R1 out", outv, 8'h00);
        chk("R1 pu", pu, 8'h00);
        pins = 8'h5A;
        for (int a = 0; a <= 10; a++) begin
            rd1(ctl(STRAP, 1'b1), 8'(a), v);
            if (a == 9) chk("R4 port at reset", v, 8'h5A);
            else chk("R1 register reset", v, (a == 0) ? 8'hFF : 8'h00);
        end
        rd1(ctl(STRAP, 1'b1), 8'h0B, v); chk("R5 read above range", v, 8'h00);
        rd1(ctl(STRAP, 1'b1), 8'hFF, v); chk("R5 read far above", v, 8'h00);

        // R2 write and read back, R3 pin drive
        for (int a = 0; a <= 10; a++) begin
            if (a >= 7 && a <= 9) continue;
            wr(ctl(STRAP, 1'b0), 8'(a), pat(a));
            rd1(ctl(STRAP, 1'b1), 8'(a), v);
            chk("R2 readback", v, pat(a));
        end
        chk("R3 oe inverse of dir", oe, ~pat(0));
        chk("R3 out equals latch", outv, pat(10));
        chk("R3 pu equals pull", pu, pat(6));

        // R4 port read inversion
        wr(ctl(STRAP, 1'b0), 8'h01, 8'h0F);
        for (int k = 0; k < 4; k++) begin
            pins = 8'(k * 8'h55 + 8'h3C);
            rd1(ctl(STRAP, 1'b1), 8'h09, v);
            chk("R4 port xor inversion", v, pins ^ 8'h0F);
        end

        // R5 status registers ignore writes
        do_reset(); pins = 8'h00;
        repeat (3) @(negedge clk);
        wr(ctl(STRAP, 1'b0), 8'h07, 8'hFF);
        wr(ctl(STRAP, 1'b0), 8'h08, 8'hFF);
        wr(ctl(STRAP, 1'b0), 8'h09, 8'hFF);
        wr(ctl(STRAP, 1'b0), 8'h0B, 8'hFF);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R5 flag write ignored", v, 8'h00);
        rd1(ctl(STRAP, 1'b1), 8'h08, v); chk("R5 snap write ignored", v, 8'h00);
        rd1(ctl(STRAP, 1'b1), 8'h0B, v); chk("R5 out of range write", v, 8'h00);
        chk("R5 port write leaves latch", outv, 8'h00);
        chk("R5 oe untouched", oe, 8'h00);

        // R6 device field ignored when matching is off
        wr(ctl(3'b010, 1'b0), 8'h0A, 8'h6E);
        chk("R6 any device number accepted", outv, 8'h6E);
        wr(8'h64, 8'h0A, 8'h77);
        chk("R6 wrong tag ignored", outv, 8'h6E);

        // R7 device matching on: sweep every device number
        wr(ctl(STRAP, 1'b0), 8'h05, 8'h08);
        prev = outv;
        for (int h = 0; h < 8; h++) begin
            wr(ctl(3'(h), 1'b0), 8'h0A, 8'(8'h10 + h));
            if (3'(h) == STRAP) prev = 8'(8'h10 + h);
            chk("R7 only strap match writes", outv, prev);
            rd1(ctl(3'(h), 1'b1), 8'h0A, v);
            chk("R7 read gated by match", v, (3'(h) == STRAP) ? prev : 8'h00);
        end

        // R8 auto increment with wrap
        do_reset();
        frame(ctl(STRAP, 1'b0), 8'h0A, 3, 24'hC30F55, r);
        chk("R8 first byte latch", outv, 8'hC3);
        chk("R8 wrapped to dir", oe, 8'hF0);
        rd1(ctl(STRAP, 1'b1), 8'h01, v); chk("R8 third byte inversion", v, 8'h55);
        pins = 8'h81;
        repeat (3) @(negedge clk);
        frame(ctl(STRAP, 1'b1), 8'h09, 3, 24'h0, r);
        chk("R8 burst read port", r[23:16], 8'h81 ^ 8'h55);
        chk("R8 burst read latch", r[15:8], 8'hC3);
        chk("R8 burst read wraps", r[7:0], 8'h0F);

        // R9 held pointer
        wr(ctl(STRAP, 1'b0), 8'h05, 8'h20);
        frame(ctl(STRAP, 1'b0), 8'h0A, 3, 24'h112233, r);
        chk("R9 last byte kept", outv, 8'h33);
        chk("R9 dir untouched", oe, 8'hF0);
        frame(ctl(STRAP, 1'b1), 8'h0A, 3, 24'h0, r);
        chk("R9 repeat read 0", r[23:16], 8'h33);
        chk("R9 repeat read 1", r[15:8], 8'h33);
        chk("R9 repeat read 2", r[7:0], 8'h33);

        // R10 chip-select abort
        do_reset();
        wr(ctl(STRAP, 1'b0), 8'h0A, 8'h5A);
        @(negedge clk); cs_n = 1'b0;
        spi_bits(ctl(STRAP, 1'b0), 8, junk);
        spi_bits(8'h0A, 8, junk);
        spi_bits(8'hFF, 4, junk);
        repeat (2) @(negedge clk); cs_n = 1'b1; repeat (4) @(negedge clk);
        chk("R10 partial byte dropped", outv, 8'h5A);
        @(negedge clk); cs_n = 1'b0;
        spi_bits(ctl(STRAP, 1'b0), 3, junk);
        repeat (2) @(negedge clk); cs_n = 1'b1; repeat (4) @(negedge clk);
        wr(ctl(STRAP, 1'b0), 8'h0A, 8'h66);
        chk("R10 fresh frame after abort", outv, 8'h66);

        // R11 change interrupt, capture and clear
        do_reset(); pins = 8'h00;
        repeat (3) @(negedge clk);
        wr(ctl(STRAP, 1'b0), 8'h02, 8'h01);
        pins = 8'h01; repeat (4) @(negedge clk);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R11 flag set on change", v, 8'h01);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R11 flag read keeps flag", v, 8'h01);
        rd1(ctl(STRAP, 1'b1), 8'h08, v); chk("R11 capture value", v, 8'h01);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R11 capture read clears", v, 8'h00);
        pins = 8'h00; repeat (4) @(negedge clk);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R11 falling change flags", v, 8'h01);
        rd1(ctl(STRAP, 1'b1), 8'h09, v); chk("R11 port read value", v, 8'h00);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R11 port read clears", v, 8'h00);

        // R12 compare interrupt
        do_reset(); pins = 8'h00;
        repeat (3) @(negedge clk);
        wr(ctl(STRAP, 1'b0), 8'h04, 8'h02);
        wr(ctl(STRAP, 1'b0), 8'h02, 8'h02);
        pins = 8'h02; repeat (4) @(negedge clk);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R12 mismatch flags", v, 8'h02);
        rd1(ctl(STRAP, 1'b1), 8'h09, v);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R12 flag reasserts", v, 8'h02);
        pins = 8'h00; repeat (4) @(negedge clk);
        rd1(ctl(STRAP, 1'b1), 8'h09, v);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R12 cleared once matched", v, 8'h00);

        // R13 outputs and disabled pins never flag
        do_reset(); pins = 8'h00;
        repeat (3) @(negedge clk);
        wr(ctl(STRAP, 1'b0), 8'h00, 8'hFE);
        wr(ctl(STRAP, 1'b0), 8'h02, 8'h03);
        pins = 8'h01; repeat (4) @(negedge clk);
        pins = 8'h04; repeat (4) @(negedge clk);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R13 output and disabled pins quiet", v, 8'h00);
        pins = 8'h06; repeat (4) @(negedge clk);
        rd1(ctl(STRAP, 1'b1), 8'h07, v); chk("R13 enabled input flags", v, 8'h02);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule